// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Unit

This block keeps the interrupt and transfer status of a two-channel IDE host controller and merges it into one host interrupt line. Each channel owns a bus-master command byte and a bus-master status byte. A shared mode byte holds one pending flag and one block (mask) bit per channel. Each channel also has an alternate interrupt flag that sits in its own configuration byte.

A rising edge on a channel's drive interrupt line raises that channel's interrupt in all three views at once: the status interrupt bit, the mode pending flag and the alternate flag. Software may acknowledge the interrupt by writing one to any of the three views. Any such write clears all three, so the views never disagree. The DMA side reports errors and completed transfers on per-channel pulse inputs. Software starts and stops a transfer through bit 0 of the command byte.

Registers are reached through a byte-wide port. Writes are synchronous and reads are combinational. The map is: 0 ch0 command, 1 ch0 status, 2 ch1 command, 3 ch1 status, 4 mode, 5 ch0 configuration, 6 ch1 configuration. Any other address reads zero.

Top module: `ide_irq_status_unit`

## Requirements
- R1: After reset every register reads 0x00 and `host_irq_o` is low.
- R2: On a clock where `drv_irq_i[c]` is high and was low on the previous clock, channel c's interrupt is set in three places: status bit 2, mode bit 2+c, and its alternate flag (bit 1 of address 5 for ch0, bit 4 of address 6 for ch1). A line held high does not set the interrupt again after it is cleared.
- R3: Writing 1 to any of the three interrupt views of a channel clears all three in the same clock. Writing 0 to them changes nothing. The three views always agree.
- R4: A pulse on `dma_err_i[c]` sets status bit 1 of channel c. Writing 1 to that bit clears it.
- R5: Status bit 0 (active) is read-only. It is set by a command write with bit 0 = 1 while command bit 0 was 0. It is cleared by a command write with bit 0 = 0, or by a `dma_done_i[c]` pulse. It is never set while command bit 0 is 0.
- R6: `host_irq_o` is registered. It shows, one clock late, the OR over channels of (pending AND status interrupt AND NOT blocked).
- R7: Mode bit 4 blocks ch0 and mode bit 5 blocks ch1. A blocked channel keeps its flags but does not raise `host_irq_o`.
- R8: If a drive interrupt edge and a write-one clear hit the same clock, the set wins.
- R9: Mode bits 0, 1, 6 and 7, command bits 7:1, and every configuration bit other than the alternate flag are plain read/write storage. Status bits 7:3 read 0.
- R10: A transfer that ended cleanly reads exactly 100b in status bits 2:0 (interrupt set, no error, not active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drv_irq_i | input | 2 | Drive interrupt line per channel |
| dma_err_i | input | 2 | DMA error pulse per channel |
| dma_done_i | input | 2 | DMA transfer-finished pulse per channel |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| host_irq_o | output | 1 | Combined host interrupt |

## Verification
The assertions assume that every input is synchronous to `clk_i`. They also assume that the error and done inputs are single-clock pulses, and that a drive line counts as a new interrupt only on the clock after it was sampled low. The stimulus changes inputs only on the falling clock edge and holds each interrupt line for many clocks. It never pulses error and done together with a start write, except in the cases meant to exercise priority. Reads take place on clocks with no write, so each sampled value reflects only the state that the previous edges left behind.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NCH    = 2;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;
  localparam logic [AW-1:0] A_CMD0  = 3'd0;
  localparam logic [AW-1:0] A_STAT0 = 3'd1;
  localparam logic [AW-1:0] A_CMD1  = 3'd2;
  localparam logic [AW-1:0] A_STAT1 = 3'd3;
  localparam logic [AW-1:0] A_MODE  = 3'd4;
  localparam logic [AW-1:0] A_CFG0  = 3'd5;
  localparam logic [AW-1:0] A_CFG1  = 3'd6;

  function automatic int alt_pos(input int ch);
    return (ch == 0) ? 1 : 4;
  endfunction
endpackage

// File: rtl/ide_chan_state.sv
module ide_chan_state
  import ide_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  input  logic          err_i,
  input  logic          done_i,
  input  logic          cmd_we_i,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_clr_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] stat_o,
  output logic          pend_o,
  output logic          alt_o
);
  logic [DW-1:0] cmd_q;
  logic irq_prev_q, act_q, err_q, intr_q, pend_q, alt_q;
  logic rise, clr, start, stop;

  assign rise  = irq_i & ~irq_prev_q;
  assign clr   = ext_clr_i | (stat_we_i & wdata_i[2]);
  assign start = cmd_we_i & wdata_i[0] & ~cmd_q[0];
  assign stop  = (cmd_we_i & ~wdata_i[0]) | done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= '0;
      irq_prev_q <= 1'b0;
      act_q      <= 1'b0;
      err_q      <= 1'b0;
      intr_q     <= 1'b0;
      pend_q     <= 1'b0;
      alt_q      <= 1'b0;
    end else begin
      irq_prev_q <= irq_i;
      if (cmd_we_i) cmd_q <= wdata_i;
      if (start)     act_q <= 1'b1;
      else if (stop) act_q <= 1'b0;
      if (err_i)                       err_q <= 1'b1;
      else if (stat_we_i & wdata_i[1]) err_q <= 1'b0;
      // set has priority over any clear
      if (rise) begin
        intr_q <= 1'b1;
        pend_q <= 1'b1;
        alt_q  <= 1'b1;
      end else if (clr) begin
        intr_q <= 1'b0;
        pend_q <= 1'b0;
        alt_q  <= 1'b0;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = {{(DW-3){1'b0}}, intr_q, err_q, act_q};
  assign pend_o = pend_q;
  assign alt_o  = alt_q;

  // R3
  views_agree_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == intr_q) && (alt_q == intr_q));
  // R2
  edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !irq_prev_q) |=> (pend_o && alt_o && stat_o[2]));
  // R4
  err_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_o[1]);
  // R5
  idle_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o[0] |-> !stat_o[0]);
endmodule

// File: rtl/ide_host_irq.sv
module ide_host_irq
  import ide_irq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pend_i,
  input  logic [NCH-1:0] intr_i,
  input  logic [NCH-1:0] blk_i,
  output logic           irq_o
);
  logic irq_q;
  logic [NCH-1:0] live;

  assign live = pend_i & intr_i & ~blk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |live;
  end

  assign irq_o = irq_q;

  // R6
  host_irq_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & intr_i & ~blk_i)) |=> irq_o);
  // R7
  blocked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&blk_i) |=> !irq_o);
endmodule

// File: rtl/ide_irq_status_unit.sv
module ide_irq_status_unit
  import ide_irq_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] drv_irq_i,
  input  logic [NCH-1:0] dma_err_i,
  input  logic [NCH-1:0] dma_done_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic           reg_we_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           host_irq_o
);
  logic [DW-1:0] mode_store_q;
  logic [DW-1:0] cfg_store_q [NCH];
  logic [DW-1:0] cmd_v  [NCH];
  logic [DW-1:0] stat_v [NCH];
  logic [DW-1:0] cfg_v  [NCH];
  logic [NCH-1:0] pend, alt, intr, blk;
  logic [DW-1:0] mode_v;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int AP = alt_pos(g);
    localparam logic [AW-1:0] A_CMD  = AW'(2*g);
    localparam logic [AW-1:0] A_STAT = AW'(2*g+1);
    localparam logic [AW-1:0] A_CFG  = AW'(5+g);
    logic cmd_we, stat_we, cfg_we, mode_we, ext_clr;

    assign cmd_we  = reg_we_i && (reg_addr_i == A_CMD);
    assign stat_we = reg_we_i && (reg_addr_i == A_STAT);
    assign cfg_we  = reg_we_i && (reg_addr_i == A_CFG);
    assign mode_we = reg_we_i && (reg_addr_i == A_MODE);
    assign ext_clr = (mode_we && reg_wdata_i[PEND_LSB+g]) ||
                     (cfg_we && reg_wdata_i[AP]);

    ide_chan_state u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (drv_irq_i[g]),
      .err_i     (dma_err_i[g]),
      .done_i    (dma_done_i[g]),
      .cmd_we_i  (cmd_we),
      .stat_we_i (stat_we),
      .wdata_i   (reg_wdata_i),
      .ext_clr_i (ext_clr),
      .cmd_o     (cmd_v[g]),
      .stat_o    (stat_v[g]),
      .pend_o    (pend[g]),
      .alt_o     (alt[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_store_q[g] <= '0;
      else if (cfg_we) cfg_store_q[g] <= reg_wdata_i;
    end

    always_comb begin
      cfg_v[g]     = cfg_store_q[g];
      cfg_v[g][AP] = alt[g];
    end

    assign intr[g] = stat_v[g][2];
    assign blk[g]  = mode_store_q[BLK_LSB+g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_store_q <= '0;
    else if (reg_we_i && reg_addr_i == A_MODE) mode_store_q <= reg_wdata_i;
  end

  always_comb begin
    mode_v = mode_store_q;
    mode_v[PEND_LSB +: NCH] = pend;
  end

  always_comb begin
    case (reg_addr_i)
      A_CMD0:  reg_rdata_o = cmd_v[0];
      A_STAT0: reg_rdata_o = stat_v[0];
      A_CMD1:  reg_rdata_o = cmd_v[1];
      A_STAT1: reg_rdata_o = stat_v[1];
      A_MODE:  reg_rdata_o = mode_v;
      A_CFG0:  reg_rdata_o = cfg_v[0];
      A_CFG1:  reg_rdata_o = cfg_v[1];
      default: reg_rdata_o = '0;
    endcase
  end

  ide_host_irq u_host_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .intr_i (intr),
    .blk_i  (blk),
    .irq_o  (host_irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !host_irq_o);
endmodule

// File: tb/ide_irq_status_unit_bench.sv
`timescale 1ns/1ps
module ide_irq_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] drv_irq = '0, dma_err = '0, dma_done = '0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       hirq;
  int n_tests = 0, n_fail = 0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  ide_irq_status_unit u_ide_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .drv_irq_i(drv_irq), .dma_err_i(dma_err),
    .dma_done_i(dma_done), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .host_irq_o(hirq));

  // monitor: compare each expected item just after the following edge
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (e[8]) begin
          if (hirq !== e[0]) begin
            n_fail++;
            $display("FAIL %s host_irq act=%0b exp=%0b", t, hirq, e[0]);
          end
        end else if (rdata !== e[7:0]) begin
          n_fail++;
          $display("FAIL %s addr=%0d act=%02h exp=%02h", t, addr, rdata, e[7:0]);
        end
      end
    end
  end

  task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string t);
    we = 1'b0; addr = a;
    exp_q.push_back({1'b0, e}); tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    exp_q.push_back({1'b1, 7'd0, e}); tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 7; i++) chk_reg(3'(i), 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // R9 storage bits
    wr(3'd4, 8'hC3); chk_reg(3'd4, 8'hC3, "R9 mode");
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hFE); chk_reg(3'd0, 8'hFE, "R9 cmd"); chk_reg(3'd1, 8'h00, "R9 stat");
    wr(3'd0, 8'h00);
    wr(3'd1, 8'hF8); chk_reg(3'd1, 8'h00, "R9 stat hi");
    wr(3'd5, 8'hFD); chk_reg(3'd5, 8'hFD, "R9 cfg0");
    wr(3'd6, 8'hEF); chk_reg(3'd6, 8'hEF, "R9 cfg1");
    wr(3'd5, 8'h00); wr(3'd6, 8'h00);

    // R2 ch0 edge, R6 latency
    drv_irq[0] = 1'b1;
    chk_irq(1'b0, "R6 lag");
    chk_reg(3'd1, 8'h04, "R2 stat0");
    chk_reg(3'd4, 8'h04, "R2 mode");
    chk_reg(3'd5, 8'h02, "R2 cfg0");
    chk_reg(3'd6, 8'h00, "R2 cfg1");
    chk_irq(1'b1, "R6");
    // R3 write zero no effect, write one via cfg clears all
    wr(3'd4, 8'h00); chk_reg(3'd4, 8'h04, "R3 zero");
    wr(3'd5, 8'h02);
    chk_reg(3'd1, 8'h00, "R3 stat0");
    chk_reg(3'd4, 8'h00, "R3 mode");
    chk_reg(3'd5, 8'h00, "R3 cfg0");
    chk_irq(1'b0, "R3 irq");
    repeat (3) @(negedge clk);
    chk_reg(3'd1, 8'h00, "R2 level");
    drv_irq[0] = 1'b0;

    // R7 blocking on ch1
    wr(3'd4, 8'h20);
    drv_irq[1] = 1'b1;
    @(negedge clk);
    chk_reg(3'd4, 8'h28, "R7 mode");
    chk_reg(3'd6, 8'h10, "R2 cfg1");
    chk_reg(3'd3, 8'h04, "R2 stat1");
    chk_irq(1'b0, "R7 blocked");
    wr(3'd4, 8'h00);
    chk_irq(1'b1, "R7 unblock");
    wr(3'd3, 8'h04);
    chk_reg(3'd4, 8'h00, "R3 mode");
    chk_reg(3'd6, 8'h00, "R3 cfg1");
    chk_irq(1'b0, "R3 irq1");
    drv_irq[1] = 1'b0;

    // R4 error
    dma_err[0] = 1'b1; @(negedge clk); dma_err[0] = 1'b0;
    chk_reg(3'd1, 8'h02, "R4 set");
    wr(3'd1, 8'h02); chk_reg(3'd1, 8'h00, "R4 clr");

    // R5 active
    wr(3'd0, 8'h01); chk_reg(3'd1, 8'h01, "R5 start");
    wr(3'd0, 8'h00); chk_reg(3'd1, 8'h00, "R5 stop");
    wr(3'd0, 8'h01);
    dma_done[0] = 1'b1; @(negedge clk); dma_done[0] = 1'b0;
    chk_reg(3'd1, 8'h00, "R5 done");
    chk_reg(3'd0, 8'h01, "R5 cmd");
    wr(3'd0, 8'h00);

    // R10 clean end on ch1
    wr(3'd2, 8'h01);
    drv_irq[1] = 1'b1; dma_done[1] = 1'b1;
    @(negedge clk); dma_done[1] = 1'b0;
    chk_reg(3'd3, 8'h04, "R10");
    wr(3'd2, 8'h00); wr(3'd3, 8'h04);
    drv_irq[1] = 1'b0;

    // R8 set beats clear
    drv_irq[0] = 1'b1;
    wr(3'd1, 8'h04);
    chk_reg(3'd1, 8'h04, "R8 stat0");
    chk_reg(3'd4, 8'h04, "R8 mode");

    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule